// File: doc/BRIEF.md
# Variable-Clock Delay Test Sequencer

This block drives a delay test for a sequential circuit that has no scan access. A stored list of N test vectors is replayed N times. On each replay, one vector position is clocked at the rated speed and every other position is clocked slowly. The positions before the rated one bring the circuit to a known state. The positions after it carry any captured timing error out to the outputs. Because a slow clock lets even a faulty circuit settle correctly, only the rated frame can expose a delay defect. From one pass to the next, the rated position moves through every vector index.

The sequencer runs from a fast reference clock. It does not generate a clock itself. Instead it emits a one-reference-cycle edge request, `cut_tick`, which an external gate turns into the clock of the circuit under test. While each vector is held, it presents the vector index, the pass index and a rated marker. A strobe pulse tells an external comparator when a vector boundary has passed, and `done` reports that the whole N-by-N schedule has finished. The vector memory, the response comparison and the fault analysis are outside this block.

Top module: `varclk_test_seq`

## Requirements
- R1: While reset is high and after it is released without a start, `done`, `cut_tick`, `rated` and `strobe` are 0, and `vec_idx` and `pass_idx` are 0.
- R2: A start with `num_vec` = N ≥ 1 produces exactly N·N edge requests. They come in passes 0 to N-1, and within each pass `vec_idx` steps 0, 1, …, N-1. The index outputs change only in the cycle after an edge request.
- R3: `rated` is high exactly while a run is active and `vec_idx` equals `pass_idx`. Each pass contains exactly one edge request with `rated` high.
- R4: The edge request of a rated vector comes one reference cycle after the previous edge request. For the first vector of a run, it comes one cycle after the start was sampled.
- R5: The edge request of a slow vector comes `slow_div` reference cycles after the previous edge request, or after the start for the first vector. A `slow_div` of 0 behaves as 1.
- R6: `strobe` is high for exactly the one cycle after each edge request, and at no other time.
- R7: `done` rises in the cycle after the final edge request and holds, with no further edge request and `rated` low, until the next start. A run spans N·(N-1)·max(`slow_div`,1) + N reference cycles, from its first cycle through its final edge request.
- R8: A start raised while a run is active has no effect on the schedule.
- R9: A start with `num_vec` = 0 sets `done` in the next cycle and produces no edge request.
- R10: `num_vec` and `slow_div` are captured at start. Changing them during a run does not alter the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle or finished |
| num_vec | input | IDX_W | Vector count N |
| slow_div | input | DIV_W | Slow period in reference cycles |
| vec_idx | output | IDX_W | Index of the vector currently applied |
| pass_idx | output | IDX_W | Current pass, which is also the rated position |
| cut_tick | output | 1 | One-cycle request for a clock edge of the circuit under test |
| rated | output | 1 | Current vector is the rated one |
| strobe | output | 1 | Pulse one cycle after each edge request |
| done | output | 1 | Whole schedule completed |

## Verification
The bench sweeps small vector counts against every slow ratio from 0 to 3. In each cycle it predicts the index pair, the rated marker and whether an edge request is due, all from elapsed-cycle arithmetic.

Several corner cases are covered, each aimed at a specific error:
- A rated position at index 0 or at N-1. An off-by-one in the pass wrap would show up here as a missing or doubled rated edge.
- A slow ratio of 0. A design that did not clamp it would wrap its counter and stall for a whole counter range.
- N = 1 and N = 0. A design that got these wrong would either never finish or emit a stray edge.
- A run in which start, N and the ratio are all disturbed mid-run. A design that did not lock its settings would restart, or would stretch its slow periods.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    parameter int IDX_W = 4;
    parameter int DIV_W = 8;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_st_e;

    // position in the N x N schedule
    typedef struct packed {
        idx_t pass;
        idx_t vec;
    } pos_t;

    // a zero ratio behaves as one reference cycle
    function automatic div_t eff_div(input div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction

    // reference cycles between the previous edge and this vector's edge
    function automatic div_t period_of(input pos_t p, input div_t slow);
        return (p.vec == p.pass) ? div_t'(1) : slow;
    endfunction

endpackage

// File: rtl/vcs_edge_timer.sv
module vcs_edge_timer
    import vcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  div_t period,
    output logic tick
);

    div_t cnt_q;

    assign tick = run && (cnt_q == period - div_t'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + div_t'(1);
        end
    end

    // slow spacing never overshoots its period
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < period));

endmodule

// File: rtl/vcs_walker.sv
module vcs_walker
    import vcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  idx_t num_vec,
    input  logic advance,
    output pos_t pos,
    output logic running,
    output logic done
);

    localparam idx_t ONE = idx_t'(1);

    seq_st_e st_q;
    idx_t    n_q;
    idx_t    last;

    assign last    = n_q - ONE;
    assign running = (st_q == ST_RUN);
    assign done    = (st_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            pos  <= '0;
            n_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        pos  <= '0;
                        n_q  <= num_vec;
                        st_q <= (num_vec == '0) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (advance) begin
                        if (pos.vec == last) begin
                            pos.vec <= '0;
                            if (pos.pass == last) begin
                                st_q <= ST_DONE;
                            end else begin
                                pos.pass <= pos.pass + ONE;
                            end
                        end else begin
                            pos.vec <= pos.vec + ONE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    p_pos_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        running |-> (pos.vec < n_q && pos.pass < n_q));

    p_pos_still_r2: assert property (@(posedge clk) disable iff (rst)
        (running && !advance) |=> $stable(pos));

    p_restart_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (running && start) |=> (running || done));

    p_count_locked_r10: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(n_q));

endmodule

// File: rtl/varclk_test_seq.sv
module varclk_test_seq
    import vcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] num_vec,
    input  logic [DIV_W-1:0] slow_div,
    output logic [IDX_W-1:0] vec_idx,
    output logic [IDX_W-1:0] pass_idx,
    output logic             cut_tick,
    output logic             rated,
    output logic             strobe,
    output logic             done
);

    pos_t pos;
    logic running;
    div_t div_q;
    div_t period;
    logic strobe_q;

    vcs_walker u_walker (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .num_vec (num_vec),
        .advance (cut_tick),
        .pos     (pos),
        .running (running),
        .done    (done)
    );

    // slow ratio is captured together with the vector count
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= div_t'(1);
        end else if (start && !running) begin
            div_q <= eff_div(slow_div);
        end
    end

    assign period = period_of(pos, div_q);

    vcs_edge_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (running),
        .period (period),
        .tick   (cut_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= cut_tick;
        end
    end

    assign vec_idx  = pos.vec;
    assign pass_idx = pos.pass;
    assign rated    = running && (pos.vec == pos.pass);
    assign strobe   = strobe_q;

    p_rated_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (cut_tick && rated) |-> ($past(cut_tick) || !$past(running)));

    p_single_rated_r3: assert property (@(posedge clk) disable iff (rst)
        (cut_tick && rated) |=> !rated);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cut_tick && !rated));

    p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    p_div_locked_r10: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> $stable(div_q));

endmodule

// File: tb/varclk_test_seq_test.sv
module varclk_test_seq_test;
    import vcs_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [IDX_W-1:0] num_vec = '0;
    logic [DIV_W-1:0] slow_div = '0;
    logic [IDX_W-1:0] vec_idx, pass_idx;
    logic             cut_tick, rated, strobe, done;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    varclk_test_seq uut (
        .clk(clk), .rst(rst), .start(start), .num_vec(num_vec),
        .slow_div(slow_div), .vec_idx(vec_idx), .pass_idx(pass_idx),
        .cut_tick(cut_tick), .rated(rated), .strobe(strobe), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int n, input int d, input bit poke);
        int    de = (d == 0) ? 1 : d;
        int    ev = 0, ep = 0, since = 0, cyc = 0, ticks = 0, rticks = 0;
        int    p;
        bit    exp_tick, prev_tick = 1'b0, fin = 1'b0;
        string rq = poke ? "R2 R8 R10" : "R2";
        @(negedge clk);
        num_vec = IDX_W'(n); slow_div = DIV_W'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R9", "done after empty start", done, 1);
            chk(cut_tick == 1'b0, "R9", "edge on empty run", cut_tick, 0);
            @(negedge clk);
            chk(done == 1'b1 && cut_tick == 1'b0, "R9", "empty run stays done", done, 1);
            return;
        end
        for (int k = 0; k < 50000; k++) begin
            since++; cyc++;
            if (poke && k == 2) begin start = 1'b1; num_vec = IDX_W'(7); slow_div = DIV_W'(5); end
            if (poke && k == 3) start = 1'b0;
            p = (ev == ep) ? 1 : de;
            exp_tick = (since == p);
            chk(vec_idx == IDX_W'(ev), rq, "vec_idx", vec_idx, ev);
            chk(pass_idx == IDX_W'(ep), rq, "pass_idx", pass_idx, ep);
            chk(rated == (ev == ep), "R3", "rated", rated, (ev == ep));
            chk(cut_tick == exp_tick, (ev == ep) ? "R4" : "R5", "cut_tick", cut_tick, exp_tick);
            chk(strobe == prev_tick, "R6", "strobe", strobe, prev_tick);
            chk(done == 1'b0, "R7", "done early", done, 0);
            prev_tick = exp_tick;
            if (exp_tick) begin
                ticks++;
                if (ev == ep) rticks++;
                since = 0;
                if (ev == n - 1) begin
                    chk(rticks == 1, "R3", "rated edges in pass", rticks, 1);
                    rticks = 0;
                    ev = 0;
                    if (ep == n - 1) begin
                        fin = 1'b1;
                        break;
                    end
                    ep++;
                end else begin
                    ev++;
                end
            end
            @(negedge clk);
        end
        chk(fin, "R7", "run finished", fin, 1);
        @(negedge clk);
        chk(done == 1'b1, "R7", "done after last edge", done, 1);
        chk(strobe == 1'b1, "R6", "strobe after last edge", strobe, 1);
        chk(cut_tick == 1'b0 && rated == 1'b0, "R7", "quiet when done", cut_tick, 0);
        chk(ticks == n * n, "R2", "edge count", ticks, n * n);
        chk(cyc == n * (n - 1) * de + n, "R7", "run length", cyc, n * (n - 1) * de + n);
        @(negedge clk);
        chk(done == 1'b1 && cut_tick == 1'b0, "R7", "done holds", done, 1);
        chk(strobe == 1'b0, "R6", "single strobe", strobe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(done == 0 && cut_tick == 0 && rated == 0 && strobe == 0, "R1",
            "outputs in reset", {done, cut_tick, rated, strobe}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 0 && cut_tick == 0 && rated == 0 && strobe == 0, "R1",
            "idle outputs", {done, cut_tick, rated, strobe}, 0);
        chk(vec_idx == 0 && pass_idx == 0, "R1", "idle indices", vec_idx, 0);
        for (int n = 1; n <= 5; n++) begin
            for (int d = 0; d <= 3; d++) begin
                run_case(n, d, 1'b0);
            end
        end
        run_case(0, 2, 1'b0);
        run_case(3, 2, 1'b1);
        run_case(15, 2, 1'b0);
        run_case(2, 7, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule